// File: doc/BRIEF.md
# Receive Buffer Segmenter

This block takes a received frame, one byte per accepted cycle with start and end markers, and spreads it over system-memory buffers. The buffers are taken in turn from a ring of receive descriptors. For every byte it issues a write request naming the descriptor, the offset inside that buffer and the byte itself. Whenever a buffer is closed, it issues a descriptor status update. That update gives the number of bytes placed in the buffer, a start-of-frame flag, an end-of-frame flag and, on the final buffer only, the total frame length.

The buffer size is programmed as a code in 64-byte units. Two options change how the frame is cut. In elastic mode the descriptor at the end of the ring takes the rest of a frame whatever its length, and each frame starts at descriptor 0. In header-split mode the first `cfg_hdr_len` bytes of a frame are closed off in their own buffers, and the payload starts in a fresh buffer.

Every output is registered and follows the accepted byte by one clock. The ring's last index and all configuration are inputs. They are expected to be stable while a frame is in flight.

Top module: `rx_buf_segmenter`

## Requirements
- R1: A buffer that is not elastic is closed after exactly `cfg_size_code`×64 bytes. For example, code 1 gives 64 bytes and code 2 gives 128 bytes.
- R2: `cfg_err` is 1 exactly when `cfg_size_code` is zero. While the code is zero, buffers are cut at 64 bytes.
- R3: After the buffer at index `cfg_ring_last` is closed, the next buffer is index 0. Otherwise the next buffer is the current index plus 1.
- R4: With `cfg_elastic_en`=1, the buffer at index `cfg_ring_last` is never closed because of its size. It receives bytes at increasing offsets until the frame ends.
- R5: With `cfg_elastic_en`=1, the first byte of every frame goes to index 0 at offset 0.
- R6: With `cfg_split_en`=1, a buffer is also closed after the byte at which the frame count reaches `cfg_hdr_len`. The next byte goes to a new buffer at offset 0.
- R7: With both options off, a frame fills buffers back to back. Each buffer starts at offset 0, and offsets increase by 1 per byte.
- R8: Every status update has `bd_sof`=1 for the first buffer of a frame and `bd_eof`=1 for its last buffer. `bd_len` equals the total frame length when `bd_eof`=1 and is 0 otherwise.
- R9: A frame that ends on a size boundary closes that buffer exactly once, with `bd_eof`=1. The next frame starts in the following descriptor, so no empty buffer is reported.
- R10: An accepted byte appears one clock later on `wr_valid`/`wr_idx`/`wr_off`/`wr_data`. When it closes a buffer, `bd_valid` rises in the same cycle with `bd_cnt` equal to its offset plus 1.
- R11: After reset, `wr_valid` and `bd_valid` are 0, and the first byte accepted goes to index 0 at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size_code | input | 8 | Buffer size in 64-byte units |
| cfg_elastic_en | input | 1 | Last ring buffer takes the rest of the frame |
| cfg_split_en | input | 1 | Close header in its own buffers |
| cfg_hdr_len | input | HDR_W | Header length in bytes for splitting |
| cfg_ring_last | input | IDX_W | Index of the descriptor carrying the wrap bit |
| cfg_err | output | 1 | Size code is zero |
| in_valid | input | 1 | Byte accepted this cycle |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | DATA_W | Frame byte |
| wr_valid | output | 1 | Write request valid |
| wr_idx | output | IDX_W | Descriptor index of the write |
| wr_off | output | CNT_W | Byte offset in the buffer |
| wr_data | output | DATA_W | Byte to write |
| bd_valid | output | 1 | Descriptor status update valid |
| bd_idx | output | IDX_W | Descriptor being closed |
| bd_cnt | output | CNT_W | Bytes placed in that buffer |
| bd_sof | output | 1 | Buffer holds the frame start |
| bd_eof | output | 1 | Buffer holds the frame end |
| bd_len | output | CNT_W | Total frame length on the last buffer, else 0 |

## Verification
The assertions assume well-formed framing: `in_sof` marks the first accepted byte of each frame and `in_eof` its last. They also assume that configuration and `cfg_ring_last` do not change inside a frame, and that `cfg_hdr_len` is nonzero when splitting is on. The stimulus changes configuration only between frames. It always sends complete frames, and sometimes leaves idle cycles between bytes. It keeps frames below the counter range.

// File: rtl/rx_buf_segmenter.sv
module rx_buf_segmenter #(
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 16,
  parameter int HDR_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_size_code,
  input  logic              cfg_elastic_en,
  input  logic              cfg_split_en,
  input  logic [HDR_W-1:0]  cfg_hdr_len,
  input  logic [IDX_W-1:0]  cfg_ring_last,
  output logic              cfg_err,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [CNT_W-1:0]  wr_off,
  output logic [DATA_W-1:0] wr_data,
  output logic              bd_valid,
  output logic [IDX_W-1:0]  bd_idx,
  output logic [CNT_W-1:0]  bd_cnt,
  output logic              bd_sof,
  output logic              bd_eof,
  output logic [CNT_W-1:0]  bd_len
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [IDX_W-1:0] cur_idx;
  logic [CNT_W-1:0] off_q, flen_q;
  logic             first_q;

  logic [7:0]       code_eff;
  logic [CNT_W-1:0] cap, off_nx, flen_nx;
  logic [IDX_W-1:0] use_idx, next_idx;
  logic             on_last, size_end, hdr_end, close;

  assign cfg_err  = (cfg_size_code == 8'd0);
  assign code_eff = cfg_err ? 8'd1 : cfg_size_code;
  assign cap      = CNT_W'({code_eff, 6'b0});
  assign use_idx  = (in_sof && cfg_elastic_en) ? '0 : cur_idx;
  assign on_last  = (use_idx == cfg_ring_last);
  assign off_nx   = off_q + ONE;
  assign flen_nx  = flen_q + ONE;
  assign size_end = !(cfg_elastic_en && on_last) && (off_nx == cap);
  assign hdr_end  = cfg_split_en && (flen_nx == CNT_W'(cfg_hdr_len));
  assign close    = in_eof || size_end || hdr_end;
  assign next_idx = (on_last || (in_eof && cfg_elastic_en)) ? '0 : use_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= '0;
      off_q   <= '0;
      flen_q  <= '0;
      first_q <= 1'b1;
    end else if (in_valid) begin
      if (close) begin
        cur_idx <= next_idx;
        off_q   <= '0;
        first_q <= in_eof;
      end else begin
        cur_idx <= use_idx;
        off_q   <= off_nx;
      end
      flen_q <= in_eof ? '0 : flen_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      bd_valid <= 1'b0;
    end else begin
      wr_valid <= in_valid;
      bd_valid <= in_valid && close;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      wr_idx  <= use_idx;
      wr_off  <= off_q;
      wr_data <= in_data;
      bd_idx  <= use_idx;
      bd_cnt  <= off_nx;
      bd_sof  <= first_q;
      bd_eof  <= in_eof;
      bd_len  <= in_eof ? flen_nx : '0;
    end
  end
endmodule

module rx_buf_segmenter_chk #(
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 16,
  parameter int HDR_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_size_code,
  input logic              cfg_elastic_en,
  input logic [IDX_W-1:0]  cfg_ring_last,
  input logic              wr_valid,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              bd_valid,
  input logic [IDX_W-1:0]  bd_idx,
  input logic [CNT_W-1:0]  bd_cnt,
  input logic              bd_eof,
  input logic [CNT_W-1:0]  bd_len
);
  logic [CNT_W-1:0] lim;
  assign lim = (cfg_size_code == 8'd0) ? CNT_W'(64) : CNT_W'({cfg_size_code, 6'b0});

  a_r1_cnt_within_size: assert property (@(posedge clk) disable iff (!rst_n)
    bd_valid && !(cfg_elastic_en && bd_idx == cfg_ring_last) |-> bd_cnt <= lim);
  a_r3_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_idx <= cfg_ring_last);
  a_r9_no_empty_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    bd_valid |-> bd_cnt != '0);
  a_r8_len_zero_midframe: assert property (@(posedge clk) disable iff (!rst_n)
    bd_valid && !bd_eof |-> bd_len == '0);
  a_r8_len_covers_last: assert property (@(posedge clk) disable iff (!rst_n)
    bd_valid && bd_eof |-> bd_len >= bd_cnt);
  a_r10_close_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
    bd_valid |-> wr_valid);
  a_r10_close_same_desc: assert property (@(posedge clk) disable iff (!rst_n)
    bd_valid |-> bd_idx == wr_idx);
endmodule

bind rx_buf_segmenter rx_buf_segmenter_chk #(
  .IDX_W(IDX_W), .CNT_W(CNT_W), .HDR_W(HDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_size_code(cfg_size_code),
  .cfg_elastic_en(cfg_elastic_en), .cfg_ring_last(cfg_ring_last),
  .wr_valid(wr_valid), .wr_idx(wr_idx), .bd_valid(bd_valid),
  .bd_idx(bd_idx), .bd_cnt(bd_cnt), .bd_eof(bd_eof), .bd_len(bd_len)
);

// File: tb/rx_buf_segmenter_tb.sv
module rx_buf_segmenter_tb_top;
  localparam int CLK_P = 10;
  localparam int IDX_W = 4, CNT_W = 16, HDR_W = 8, DATA_W = 8;

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_size_code = 8'd2;
  logic cfg_elastic_en = 0, cfg_split_en = 0;
  logic [HDR_W-1:0] cfg_hdr_len = 8'd14;
  logic [IDX_W-1:0] cfg_ring_last = 4'd3;
  logic cfg_err;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic wr_valid, bd_valid, bd_sof, bd_eof;
  logic [IDX_W-1:0] wr_idx, bd_idx;
  logic [CNT_W-1:0] wr_off, bd_cnt, bd_len;
  logic [DATA_W-1:0] wr_data;

  always #(CLK_P/2) clk = ~clk;

  rx_buf_segmenter #(.IDX_W(IDX_W), .CNT_W(CNT_W), .HDR_W(HDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_size_code(cfg_size_code), .cfg_elastic_en(cfg_elastic_en),
    .cfg_split_en(cfg_split_en), .cfg_hdr_len(cfg_hdr_len), .cfg_ring_last(cfg_ring_last),
    .cfg_err(cfg_err), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
    .bd_valid(bd_valid), .bd_idx(bd_idx), .bd_cnt(bd_cnt), .bd_sof(bd_sof),
    .bd_eof(bd_eof), .bd_len(bd_len));

  int n_chk = 0, n_bad = 0;
  string tag = "R11";

  int m_idx = 0, m_off = 0, m_flen = 0;
  bit m_first = 1;
  bit e_wv = 0, e_bv = 0, e_bs = 0, e_be = 0;
  int e_wi, e_wo, e_wd, e_bi, e_bc, e_bl;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(wr_valid == e_wv, "R10", "wr_valid", wr_valid, e_wv);
    if (e_wv && wr_valid) begin
      check(wr_idx == e_wi, tag, "wr_idx", wr_idx, e_wi);
      check(wr_off == e_wo, tag, "wr_off", wr_off, e_wo);
      check(wr_data == e_wd, "R10", "wr_data", wr_data, e_wd);
    end
    check(bd_valid == e_bv, tag, "bd_valid", bd_valid, e_bv);
    if (e_bv && bd_valid) begin
      check(bd_idx == e_bi, tag, "bd_idx", bd_idx, e_bi);
      check(bd_cnt == e_bc, tag, "bd_cnt", bd_cnt, e_bc);
      check(bd_sof == e_bs, "R8", "bd_sof", bd_sof, e_bs);
      check(bd_eof == e_be, "R8", "bd_eof", bd_eof, e_be);
      check(bd_len == e_bl, "R8", "bd_len", bd_len, e_bl);
    end
  endtask

  task automatic step(input bit v, input bit s, input bit e, input int d);
    int cap;
    bit elast, shut;
    @(negedge clk);
    compare();
    e_wv = v; e_bv = 0;
    if (v) begin
      if (s && cfg_elastic_en) m_idx = 0;
      cap = (cfg_size_code == 0 ? 1 : cfg_size_code) * 64;
      elast = cfg_elastic_en && (m_idx == cfg_ring_last);
      shut = e || (!elast && m_off + 1 == cap) || (cfg_split_en && m_flen + 1 == cfg_hdr_len);
      e_wi = m_idx; e_wo = m_off; e_wd = d & 8'hff;
      m_flen++;
      if (shut) begin
        e_bv = 1; e_bi = m_idx; e_bc = m_off + 1; e_bs = m_first; e_be = e;
        e_bl = e ? m_flen : 0;
        m_off = 0; m_first = e;
        if (m_idx == cfg_ring_last || (e && cfg_elastic_en)) m_idx = 0; else m_idx++;
      end else m_off++;
      if (e) m_flen = 0;
    end
    in_valid = v; in_sof = s; in_eof = e; in_data = d[7:0];
  endtask

  task automatic frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      if (i % 7 == 5) step(0, 0, 0, 0);
      step(1, i == 0, i == len - 1, (i * 13 + seed) & 8'hff);
    end
    step(0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wr_valid == 0, "R11", "wr_valid in reset", wr_valid, 0);
    check(bd_valid == 0, "R11", "bd_valid in reset", bd_valid, 0);
    rst_n = 1;
    tag = "R11"; frame(10, 1);
    tag = "R1";  frame(300, 2);
    cfg_size_code = 8'd1;
    tag = "R7";  frame(100, 3);
    tag = "R9";  frame(64, 4); frame(128, 5);
    tag = "R3";  frame(200, 6); frame(30, 7);
    cfg_size_code = 8'd0;
    #1 check(cfg_err == 1, "R2", "cfg_err zero code", cfg_err, 1);
    tag = "R2";  frame(70, 8);
    cfg_size_code = 8'd1;
    #1 check(cfg_err == 0, "R2", "cfg_err legal code", cfg_err, 0);
    cfg_elastic_en = 1;
    tag = "R5";  frame(40, 9);
    tag = "R4";  frame(330, 10); frame(20, 11); frame(256, 12);
    cfg_elastic_en = 0; cfg_split_en = 1; cfg_hdr_len = 8'd14;
    tag = "R6";  frame(100, 13); frame(14, 14); frame(64, 15);
    cfg_hdr_len = 8'd70;
    frame(150, 16);
    cfg_split_en = 0;
    step(0, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule